// File: doc/BRIEF.md
# Vector Drive Completion Controller

This block decides when a pattern-driving sequencer stops issuing vectors. The sequencer presents one step per vector through a step enable. Together with each step, the address and loop logic report three flags: the vector sits at the marked final address, the loop counter has reached its last pass, and the vector is the last one of a loop pass. The block passes step pulses on until it decides to stop. It then raises a sticky, active-low done indication, withholds every further step and parks the pattern-memory clock gate in its inactive-high state. Its status bit also appears in a small status nibble that a host can read.

There are two ways to stop. The plain stop halts on the step that carries the final-address flag. The loop stop needs two things. The last-pass flag must be captured at the moment the loop-end flag drops, which is the step that drives the loop's first vector again. After that capture, the next step that has loop-end high is the last vector of the last pass. It is driven, and stepping ends there. Because the capture waits for the restart of the loop, a last-pass flag that comes early, mid-pass, has no effect until the loop comes round. This makes up for the one-vector lead of the loop indication. A restart pulse clears all stop state and lets stepping resume.

Top module: `vec_done_ctrl`

## Requirements
- R1: During and right after reset: doneN=1, memGateN=0, statusNib=4'b0000, and stepEnOut equals stepEn.
- R2: A step (stepEn=1) with finalAddr=1 is passed on, and doneN is 0 after that clock edge.
- R3: While doneN=0, stepEnOut is 0 whatever stepEn is, so no step after the stopping one is passed on.
- R4: memGateN rises one clock after doneN falls and stays 1 while doneN=0.
- R5: statusNib bit 3 is 1 exactly when doneN=0; bits 2..0 are always 0.
- R6: A step with loopEnd=1 does not stop the block unless the last-pass state has been captured.
- R7: loopFinal is sampled only on a step where loopEnd is 0 and the previous step had loopEnd=1 (the falling step). A loopFinal pulse that is gone by the falling step has no effect.
- R8: Once the last-pass state is captured, the next step with loopEnd=1 is passed on and sets doneN=0. For a loop of L vectors and N≥2 passes, with loopFinal rising at or after the last vector of pass N-1 and before the falling step that starts pass N, exactly N·L steps are passed on.
- R9: A restart pulse clears done, the captured last-pass state and the loop-end history. One clock later doneN=1, memGateN=0 and statusNib=0.
- R10: If finalAddr and the loop stop condition are both true on the same step, the block stops on that step and status bit 3 rises exactly once.
- R11: Cycles with stepEn=0 change nothing, whatever finalAddr, loopFinal and loopEnd are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous pulse that clears all stop state |
| stepEn | input | 1 | Vector step enable from the sequencer clock path |
| finalAddr | input | 1 | Current vector is at the marked final address |
| loopFinal | input | 1 | Loop counter has reached its last pass |
| loopEnd | input | 1 | Current vector is the last of a loop pass |
| doneN | output | 1 | Active-low drive complete, sticky |
| stepEnOut | output | 1 | Gated step enable to the sequencer |
| memGateN | output | 1 | Held pattern-memory clock gate, active low |
| statusNib | output | 4 | Status nibble, bit 3 = drive complete |

## Verification
On every cycle the assertions check that a final-address step stops the block, that steps are withheld while done, that the memory gate follows done, that the status nibble matches done, that idle cycles hold done, that restart clears everything, and that captured last-pass state is kept. Only the bench's scenarios can show the exact stop position of a counted loop. The bench therefore sweeps loop lengths, pass counts, early and mid-pass last-pass flags, gap cycles and coinciding stop conditions, and it checks the number of steps passed on and the number of status rises against values it computes itself.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic clearAll;   // restart: drop every piece of stop state
    logic edgeLoad;   // record loopEnd for falling-edge detection
    logic armSet;     // capture the last-pass condition
    logic doneSet;    // stop after this step
  } vdc_strobe_t;

  localparam int STATUS_W_DEF = 4;
  localparam int DONE_BIT_DEF = 3;

endpackage

// File: rtl/vdc_ctrl.sv
module vdc_ctrl
  import vdc_pkg::*;
(
  input  logic        restart,
  input  logic        stepEn,
  input  logic        finalAddr,
  input  logic        loopFinal,
  input  logic        loopEnd,
  input  logic        doneQ,
  input  logic        armedQ,
  input  logic        loopEndQ,
  output vdc_strobe_t strobe
);

  logic liveStep;
  logic loopFall;
  logic loopStop;

  always_comb begin
    // a step only counts while the block has not stopped
    liveStep = stepEn & ~doneQ;
    // loopEnd was high on the previous step and is low now: the loop restarted
    loopFall = liveStep & loopEndQ & ~loopEnd;
    // last vector of the last pass
    loopStop = armedQ & loopEnd;

    strobe.clearAll = restart;
    strobe.edgeLoad = liveStep;
    strobe.armSet   = loopFall & loopFinal;
    strobe.doneSet  = liveStep & (finalAddr | loopStop);
  end

endmodule

// File: rtl/vdc_dpath.sv
module vdc_dpath
  import vdc_pkg::*;
#(
  parameter int STATUS_W = STATUS_W_DEF,
  parameter int DONE_BIT = DONE_BIT_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  vdc_strobe_t         strobe,
  input  logic                stepEn,
  input  logic                loopEnd,
  output logic                doneQ,
  output logic                armedQ,
  output logic                loopEndQ,
  output logic                doneN,
  output logic                stepEnOut,
  output logic                memGateN,
  output logic [STATUS_W-1:0] statusNib
);

  localparam int IdleBits = STATUS_W - 1;

  logic gateEnQ;

  // sticky done
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                doneQ <= 1'b0;
    else if (strobe.clearAll) doneQ <= 1'b0;
    else if (strobe.doneSet)  doneQ <= 1'b1;
  end

  // captured last-pass state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                armedQ <= 1'b0;
    else if (strobe.clearAll) armedQ <= 1'b0;
    else if (strobe.armSet)   armedQ <= 1'b1;
  end

  // loopEnd history, advanced on live steps only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                loopEndQ <= 1'b0;
    else if (strobe.clearAll) loopEndQ <= 1'b0;
    else if (strobe.edgeLoad) loopEndQ <= loopEnd;
  end

  // held memory gate enable, dropped once done is seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gateEnQ <= 1'b1;
    else if (strobe.clearAll) gateEnQ <= 1'b1;
    else if (doneQ)           gateEnQ <= 1'b0;
  end

  assign doneN     = ~doneQ;
  assign stepEnOut = stepEn & ~doneQ;
  assign memGateN  = ~gateEnQ;

  for (genvar b = 0; b < STATUS_W; b++) begin : g_status
    if (b == DONE_BIT) begin : g_done
      assign statusNib[b] = doneQ;
    end else begin : g_zero
      assign statusNib[b] = 1'b0;
    end
  end

  a_r4_gate_follows_done: assert property (@(posedge clk) disable iff (!rstN)
    (!doneN && !strobe.clearAll) |=> memGateN);

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (doneN && !memGateN && !armedQ && !loopEndQ));

  a_r8_armed_kept: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !strobe.clearAll) |=> armedQ);

  a_r5_status_bits: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(statusNib) <= 1) && (statusNib[DONE_BIT] == ~doneN)
    && (IdleBits == STATUS_W - 1));

endmodule

// File: rtl/vec_done_ctrl.sv
module vec_done_ctrl
  import vdc_pkg::*;
#(
  parameter int STATUS_W = STATUS_W_DEF,
  parameter int DONE_BIT = DONE_BIT_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                restart,
  input  logic                stepEn,
  input  logic                finalAddr,
  input  logic                loopFinal,
  input  logic                loopEnd,
  output logic                doneN,
  output logic                stepEnOut,
  output logic                memGateN,
  output logic [STATUS_W-1:0] statusNib
);

  vdc_strobe_t strobe;
  logic        doneQ;
  logic        armedQ;
  logic        loopEndQ;

  vdc_ctrl i_ctrl (
    .restart   (restart),
    .stepEn    (stepEn),
    .finalAddr (finalAddr),
    .loopFinal (loopFinal),
    .loopEnd   (loopEnd),
    .doneQ     (doneQ),
    .armedQ    (armedQ),
    .loopEndQ  (loopEndQ),
    .strobe    (strobe)
  );

  vdc_dpath #(
    .STATUS_W (STATUS_W),
    .DONE_BIT (DONE_BIT)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stepEn    (stepEn),
    .loopEnd   (loopEnd),
    .doneQ     (doneQ),
    .armedQ    (armedQ),
    .loopEndQ  (loopEndQ),
    .doneN     (doneN),
    .stepEnOut (stepEnOut),
    .memGateN  (memGateN),
    .statusNib (statusNib)
  );

  a_r2_final_stops: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && finalAddr && !restart) |=> !doneN);

  a_r3_steps_withheld: assert property (@(posedge clk) disable iff (!rstN)
    !doneN |-> !stepEnOut);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !restart) |=> $stable(doneN));

endmodule

// File: tb/test_vec_done_ctrl.sv
module test_vec_done_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       restart = 1'b0;
  logic       stepEn = 1'b0;
  logic       finalAddr = 1'b0;
  logic       loopFinal = 1'b0;
  logic       loopEnd = 1'b0;
  logic       doneN;
  logic       stepEnOut;
  logic       memGateN;
  logic [3:0] statusNib;

  int nChecks = 0;
  int nFail = 0;
  int rises = 0;
  logic prevS = 1'b0;
  bit summaryDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_done_ctrl i_vec_done_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .stepEn(stepEn),
    .finalAddr(finalAddr), .loopFinal(loopFinal), .loopEnd(loopEnd),
    .doneN(doneN), .stepEnOut(stepEnOut), .memGateN(memGateN),
    .statusNib(statusNib)
  );

  // counts rising edges of status bit 3
  always @(posedge clk) begin
    if (statusNib[3] && !prevS) rises <= rises + 1;
    prevS <= statusNib[3];
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  // one step; returns whether it was passed on, and doneN after the edge
  task automatic doStep(input logic fa, input logic lf, input logic le,
                        output logic passed, output logic dn);
    @(negedge clk);
    stepEn = 1'b1; finalAddr = fa; loopFinal = lf; loopEnd = le;
    #1 passed = stepEnOut;
    @(posedge clk);
    #1 dn = doneN;
  endtask

  // one non-step cycle with hostile flag values (R11)
  task automatic idleCycle();
    @(negedge clk);
    stepEn = 1'b0; finalAddr = 1'b1; loopFinal = 1'b1; loopEnd = ~loopEnd;
    @(posedge clk);
    #1;
  endtask

  task automatic doRestart();
    @(negedge clk);
    stepEn = 1'b0; finalAddr = 1'b0; loopFinal = 1'b0; loopEnd = 1'b0;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9 doneN after restart", int'(doneN), 1);
    chk("R9 memGateN after restart", int'(memGateN), 0);
    chk("R9 statusNib after restart", int'(statusNib), 0);
  endtask

  // mode 0: last-pass flag at last vector of pass N-1; mode 1: mid pass N-1;
  // mode 2: flag pulses only where no falling step occurs (never captured)
  task automatic runLoop(input int L, input int N, input int mode,
                         input bit gap, input int faAt);
    int stopIdx, cnt, firstDone, rise0, total;
    logic p, dn, lf;
    if (mode == 2) stopIdx = faAt;
    else if (faAt >= 0 && faAt < N*L-1) stopIdx = faAt;
    else stopIdx = N*L-1;
    total = stopIdx + 3;
    cnt = 0; firstDone = -1; rise0 = rises;
    for (int v = 0; v < total; v++) begin
      if (mode == 0)      lf = (v >= (N-1)*L-1);
      else if (mode == 1) lf = (v >= (N-2)*L + L/2);
      else                lf = ((v % L) == L/2) && (L/2 != 0);
      doStep(v == faAt, lf, (v % L) == L-1, p, dn);
      if (p) cnt++;
      if (!dn && firstDone < 0) begin
        firstDone = v;
        chk("R4 memGateN lags doneN by one clock", int'(memGateN), 0);
      end
      if (gap && v < total-1) idleCycle();
    end
    @(negedge clk);
    stepEn = 1'b0; finalAddr = 1'b0; loopFinal = 1'b0; loopEnd = 1'b0;
    #1;
    if (faAt < 0)
      chk("R8 steps passed before loop stop", cnt, stopIdx+1);
    else if (mode == 2)
      chk("R7 early last-pass pulse ignored, steps passed", cnt, stopIdx+1);
    else
      chk("R2 steps passed before final-address stop", cnt, stopIdx+1);
    chk("R6 stop index", firstDone, stopIdx);
    chk("R3 no step passed after stop", cnt, stopIdx+1);
    chk("R4 memGateN held high", int'(memGateN), 1);
    chk("R5 statusNib while done", int'(statusNib), 8);
    chk("R10 status rises once", rises - rise0, 1);
    doRestart();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic p, dn;
    // R1 reset state
    stepEn = 1'b1;
    #(CLK_PERIOD*2 + 1);
    chk("R1 doneN in reset", int'(doneN), 1);
    chk("R1 memGateN in reset", int'(memGateN), 0);
    chk("R1 statusNib in reset", int'(statusNib), 0);
    chk("R1 stepEnOut follows stepEn", int'(stepEnOut), 1);
    @(negedge clk);
    stepEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 doneN after reset", int'(doneN), 1);
    chk("R1 stepEnOut low with no step", int'(stepEnOut), 0);

    // R11: idle cycles with all flags set change nothing
    for (int i = 0; i < 4; i++) idleCycle();
    chk("R11 doneN after idle cycles", int'(doneN), 1);

    // R6: loopEnd alone never stops
    for (int i = 0; i < 5; i++) doStep(1'b0, 1'b0, 1'b1, p, dn);
    chk("R6 loopEnd without capture", int'(dn), 1);
    doRestart();

    // R2: plain stop at several positions, with and without gaps
    for (int k = 0; k < 6; k++)
      for (int g = 0; g < 2; g++)
        runLoop(5, 4, 0, g[0], k);

    // R8/R7 sweep: loop lengths, pass counts, flag timing, gaps
    for (int L = 2; L <= 5; L++)
      for (int N = 2; N <= 4; N++)
        for (int m = 0; m < 2; m++)
          for (int g = 0; g < 2; g++)
            runLoop(L, N, m, g[0], -1);

    // R7: last-pass flag present only away from falling steps
    for (int L = 2; L <= 4; L++) runLoop(L, 3, 2, 1'b0, 4*L);

    // R10: final address on the very step the loop stop fires
    for (int L = 2; L <= 4; L++) runLoop(L, 3, 0, 1'b0, 3*L-1);

    finish_run();
  end

endmodule